// File: doc/BRIEF.md
# Event Counter Channel with Threshold Alarm

This block is a single 32-bit event counter channel. An asynchronous event line is brought into the clock domain by a synchronizer, and each rising edge becomes one count step. The step goes up or down depending on a control bit. An optional preset value can be loaded whenever a step lands the count on zero. Without that option, the count wraps modulo 2^32.

A threshold comparator raises an alarm output when the count reaches or passes a programmable level in the current counting direction. The alarm is held until the count has fallen back beyond the level by more than a 16-bit hysteresis margin. The count can only be cleared by writing a fixed key byte.

All configuration goes through a byte-wide register port. Writes are synchronous and reads are combinational. Multi-byte values are staged in shadow bytes and take effect only when their least significant byte is written, so the counter and the comparator never see a half-updated value.

Top module: `evt_counter_chan`

## Requirements
- R1: The event input passes through two synchronizer flops and one edge flop. A rising edge on `evt_in` changes the count on the third rising clock edge after the input goes high. An input held high for any length of time makes exactly one step.
- R2: Control register (address 0) bit 0 sets the direction: 0 means increment by one per event and 1 means decrement by one per event.
- R3: Control bit 7 enables counting. While it is 0, events are ignored and the count holds its value.
- R4: Control bit 2 enables reload. When a step would give a count of zero, the count takes the reload value (addresses 12..15) instead. With bit 2 clear, the count wraps modulo 2^32, so a decrement from 0 gives 0xFFFFFFFF.
- R5: Writing 0x55 to address 1 zeroes the count at the next clock edge. Address 1 reads back 0x55 if its last write was 0x55 and 0x00 otherwise. Any other value leaves the count unchanged.
- R6: Multi-byte registers are laid out with the most significant byte at the lowest address: hysteresis at 2..3, count at 4..7 (read-only), alarm level at 8..11, reload at 12..15. Writes to the upper bytes are staged in shadow bytes. The stored value changes only when the byte at the highest address of the group is written.
- R7: With control bit 1 set and bit 0 clear, `alarm_o` rises one clock after the count becomes greater than or equal to the level. It falls only when count + hysteresis < level.
- R8: With control bits 1 and 0 both set, `alarm_o` rises one clock after the count becomes less than or equal to the level. It falls only when count > level + hysteresis, for example after a reload.
- R9: With control bit 1 clear, `alarm_o` is low one clock later and stays low.
- R10: Control bits 3 to 6 read back as zero whatever value is written to them.
- R11: After reset, every register reads zero and `alarm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 1 | Asynchronous event line; a rising edge counts once |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| alarm_o | output | 1 | Threshold alarm |

## Verification
A register write takes effect at the clock edge that samples the strobe, and the combinational read port shows the new value half a cycle later. The count moves on the third edge after an event rises. The alarm follows one edge after the count, the level or the control bits it depends on. The bench drives at falling edges and reads the port a fraction of a nanosecond after a falling edge. Every write task waits one extra cycle, and every event pulse spans six cycles, so each result is sampled after the last register on its path has loaded. The event-latency check samples the count after the second edge, where it must be unchanged, and after the third edge, where it must have moved.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
package ecc_pkg;
  localparam int unsigned DIR_BIT = 0;
  localparam int unsigned ALM_BIT = 1;
  localparam int unsigned RLD_BIT = 2;
  localparam int unsigned RUN_BIT = 7;

  typedef struct packed {
    logic run;
    logic reload_en;
    logic alarm_en;
    logic down;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    logic [7:0] b;
    b          = '0;
    b[DIR_BIT] = c.down;
    b[ALM_BIT] = c.alarm_en;
    b[RLD_BIT] = c.reload_en;
    b[RUN_BIT] = c.run;
    return b;
  endfunction

  function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.down      = b[DIR_BIT];
    c.alarm_en  = b[ALM_BIT];
    c.reload_en = b[RLD_BIT];
    c.run       = b[RUN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/ecc_edge_sync.sv
`timescale 1ns/1ps
module ecc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], din};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R1: an edge produces a single-cycle step request
  p_single_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ecc_wide_reg.sv
`timescale 1ns/1ps
module ecc_wide_reg #(
  parameter int W      = 32,
  parameter int BASE   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [W-1:0]      value,
  output logic              rd_hit,
  output logic [7:0]        rd_byte
);
  localparam int NB = W / 8;
  localparam logic [ADDR_W-1:0] LSB_A = ADDR_W'(BASE + NB - 1);

  logic [W-9:0] shadow_q;
  logic         lsb_wr;
  logic         upper_wr;

  assign rd_hit   = (addr >= ADDR_W'(BASE)) && (addr <= LSB_A);
  assign lsb_wr   = wr_en && (addr == LSB_A);
  assign upper_wr = wr_en && rd_hit && (addr != LSB_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value    <= '0;
      shadow_q <= '0;
    end else begin
      if (lsb_wr) value <= {shadow_q, wdata};
      for (int i = 1; i < NB; i++)
        if (wr_en && addr == ADDR_W'(BASE + NB - 1 - i))
          shadow_q[(i-1)*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NB; i++)
      if (addr == ADDR_W'(BASE + NB - 1 - i)) rd_byte = value[i*8 +: 8];
  end

  // R6: staging an upper byte never disturbs the committed value
  p_no_torn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upper_wr |=> $stable(value));
endmodule

// File: rtl/ecc_regfile.sv
`timescale 1ns/1ps
module ecc_regfile
  import ecc_pkg::*;
#(
  parameter int         CNT_W  = 32,
  parameter int         HYS_W  = 16,
  parameter logic [7:0] MAGIC  = 8'h55,
  parameter int         A_CTRL = 0,
  parameter int         A_CLR  = 1,
  parameter int         A_HYS  = 2,
  parameter int         A_CNT  = 4,
  parameter int         A_LVL  = 8,
  parameter int         A_RLD  = 12,
  parameter int         ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  reload,
  output logic [HYS_W-1:0]  hyst,
  output logic              clr_hit
);
  localparam int CNT_B = CNT_W / 8;

  logic [7:0] clr_q;
  logic       hys_hit, lvl_hit, rld_hit, cnt_hit;
  logic [7:0] hys_byte, lvl_byte, rld_byte, cnt_byte;
  logic       ctrl_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
  assign clr_hit = wr_en && (addr == ADDR_W'(A_CLR)) && (wdata == MAGIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      clr_q <= '0;
    end else begin
      if (ctrl_wr) ctrl <= byte_to_ctrl(wdata);
      if (wr_en && addr == ADDR_W'(A_CLR)) clr_q <= (wdata == MAGIC) ? MAGIC : 8'h00;
    end
  end

  ecc_wide_reg #(.W(HYS_W), .BASE(A_HYS), .ADDR_W(ADDR_W)) u_hys (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .value(hyst), .rd_hit(hys_hit), .rd_byte(hys_byte));
  ecc_wide_reg #(.W(CNT_W), .BASE(A_LVL), .ADDR_W(ADDR_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .value(level), .rd_hit(lvl_hit), .rd_byte(lvl_byte));
  ecc_wide_reg #(.W(CNT_W), .BASE(A_RLD), .ADDR_W(ADDR_W)) u_rld (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .value(reload), .rd_hit(rld_hit), .rd_byte(rld_byte));

  always_comb begin
    cnt_hit  = (addr >= ADDR_W'(A_CNT)) && (addr <= ADDR_W'(A_CNT + CNT_B - 1));
    cnt_byte = '0;
    for (int i = 0; i < CNT_B; i++)
      if (addr == ADDR_W'(A_CNT + CNT_B - 1 - i)) cnt_byte = cnt[i*8 +: 8];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_CTRL))     rdata = ctrl_to_byte(ctrl);
    else if (addr == ADDR_W'(A_CLR)) rdata = clr_q;
    else if (hys_hit)                rdata = hys_byte;
    else if (cnt_hit)                rdata = cnt_byte;
    else if (lvl_hit)                rdata = lvl_byte;
    else if (rld_hit)                rdata = rld_byte;
  end

  // R5: the key register only ever holds the key or zero
  p_key_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q == MAGIC) || (clr_q == 8'h00));
endmodule

// File: rtl/ecc_count_core.sv
`timescale 1ns/1ps
module ecc_count_core
  import ecc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int HYS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr_hit,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] reload,
  input  logic [HYS_W-1:0] hyst,
  output logic [CNT_W-1:0] cnt_q,
  output logic             alarm_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             step_taken;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] c, input logic down, input logic rel_en,
    input logic [CNT_W-1:0] rel_val);
    logic [CNT_W-1:0] n;
    n = down ? (c - CNT_W'(1)) : (c + CNT_W'(1));
    if (rel_en && n == '0) n = rel_val;
    return n;
  endfunction

  function automatic logic alarm_next(
    input logic a, input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] lv,
    input logic [HYS_W-1:0] h, input logic down, input logic en);
    logic [CNT_W:0] ce, le, he;
    ce = {1'b0, c};
    le = {1'b0, lv};
    he = {{(CNT_W + 1 - HYS_W){1'b0}}, h};
    if (!en)                  return 1'b0;
    if (!down && ce >= le)    return 1'b1;
    if (down && ce <= le)     return 1'b1;
    if (!down && ce + he < le) return 1'b0;
    if (down && ce > le + he) return 1'b0;
    return a;
  endfunction

  assign step_taken = ctrl.run && step && !clr_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_hit)         cnt_d = '0;
    else if (step_taken) cnt_d = next_count(cnt_q, ctrl.down, ctrl.reload_en, reload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      alarm_q <= alarm_next(alarm_q, cnt_q, level, hyst, ctrl.down, ctrl.alarm_en);
    end
  end

  // R3: disabled counter holds its value
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !clr_hit) |=> $stable(cnt_q));
  // R5: key write zeroes the count
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt_q == '0));
  // R2: a plain upward step adds exactly one
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && step && !ctrl.down && !ctrl.reload_en && !clr_hit)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R9: comparison disabled forces the alarm low
  p_alarm_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.alarm_en |=> !alarm_q);
endmodule

// File: rtl/evt_counter_chan.sv
`timescale 1ns/1ps
module evt_counter_chan
  import ecc_pkg::*;
#(
  parameter int         CNT_W  = 32,
  parameter int         HYS_W  = 16,
  parameter logic [7:0] MAGIC  = 8'h55,
  localparam int        CNT_B  = CNT_W / 8,
  localparam int        HYS_B  = HYS_W / 8,
  localparam int        A_CTRL = 0,
  localparam int        A_CLR  = 1,
  localparam int        A_HYS  = 2,
  localparam int        A_CNT  = A_HYS + HYS_B,
  localparam int        A_LVL  = A_CNT + CNT_B,
  localparam int        A_RLD  = A_LVL + CNT_B,
  localparam int        ADDR_W = $clog2(A_RLD + CNT_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alarm_o
);
  logic             evt_rise;
  logic             clr_hit;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] level, reload, count;
  logic [HYS_W-1:0] hyst;

  ecc_edge_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(evt_in), .rise(evt_rise));

  ecc_regfile #(
    .CNT_W(CNT_W), .HYS_W(HYS_W), .MAGIC(MAGIC), .A_CTRL(A_CTRL), .A_CLR(A_CLR),
    .A_HYS(A_HYS), .A_CNT(A_CNT), .A_LVL(A_LVL), .A_RLD(A_RLD), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cnt(count), .ctrl(ctrl), .level(level), .reload(reload),
    .hyst(hyst), .clr_hit(clr_hit));

  ecc_count_core #(.CNT_W(CNT_W), .HYS_W(HYS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(evt_rise), .clr_hit(clr_hit), .ctrl(ctrl),
    .level(level), .reload(reload), .hyst(hyst), .cnt_q(count), .alarm_q(alarm_o));
endmodule

// File: tb/sim_evt_counter_chan.sv
`timescale 1ns/1ps
module sim_evt_counter_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_cnt = 0, m_lvl = 0, m_rld = 0;
  logic [15:0] m_hys = 0;
  logic m_alarm = 0, m_down = 0, m_alm = 0, m_rel = 0, m_run = 0;

  evt_counter_chan u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_wr(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .alarm_o(alarm));

  always #4 clk = ~clk;

  function automatic logic [31:0] m_next(input logic [31:0] c, input logic dn,
                                         input logic rel, input logic [31:0] r);
    longint v;
    v = dn ? longint'(c) - 1 : longint'(c) + 1;
    v = v & 64'hFFFF_FFFF;
    if (rel && v == 0) v = longint'(r);
    return v[31:0];
  endfunction

  function automatic logic m_alarm_f(input logic a, input logic [31:0] c,
      input logic [31:0] lv, input logic [15:0] h, input logic dn, input logic en);
    longint d;
    d = dn ? longint'(lv) - longint'(c) : longint'(c) - longint'(lv);
    if (!en) return 1'b0;
    if (d >= 0) return 1'b1;
    if (-d > longint'(h)) return 1'b0;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle_model();
    m_alarm = m_alarm_f(m_alarm, m_cnt, m_lvl, m_hys, m_down, m_alm);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd0) begin m_down = d[0]; m_alm = d[1]; m_rel = d[2]; m_run = d[7]; end
    if (a == 4'd1 && d == 8'h55) m_cnt = 0;
    @(negedge clk);
    settle_model();
  endtask

  task automatic wr32(input logic [3:0] base, input logic [31:0] v);
    wr(base, v[31:24]); wr(base + 4'd1, v[23:16]);
    wr(base + 4'd2, v[15:8]); wr(base + 4'd3, v[7:0]);
    if (base == 4'd8) m_lvl = v; else if (base == 4'd12) m_rld = v;
    settle_model();
  endtask

  task automatic wr16_hys(input logic [15:0] v);
    wr(4'd2, v[15:8]); wr(4'd3, v[7:0]);
    m_hys = v;
    settle_model();
  endtask

  // call right after a falling edge
  task automatic peek(input logic [3:0] a, output logic [7:0] b);
    addr = a; #0.5; b = rdata;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    peek(base, b0); peek(base + 4'd1, b1); peek(base + 4'd2, b2); peek(base + 4'd3, b3);
    v = {b0, b1, b2, b3};
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] b);
    @(negedge clk);
    peek(a, b);
  endtask

  task automatic pulse();
    @(negedge clk); evt = 1'b1;
    repeat (3) @(negedge clk);
    evt = 1'b0;
    repeat (3) @(negedge clk);
    if (m_run) m_cnt = m_next(m_cnt, m_down, m_rel, m_rld);
    settle_model();
  endtask

  task automatic chk_cnt(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk);
    rd32(4'd4, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_alarm(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'd0, alarm}, {31'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd8(4'd0, b); chk("R11 ctrl", {24'd0, b}, 0);
    rd8(4'd1, b); chk("R11 key", {24'd0, b}, 0);
    @(negedge clk); rd32(4'd8, v); chk("R11 level", v, 0);
    @(negedge clk); rd32(4'd12, v); chk("R11 reload", v, 0);
    chk_cnt("R11 count", 0);
    chk_alarm("R11 alarm", 1'b0);

    // R10 reserved bits
    wr(4'd0, 8'hFF); rd8(4'd0, b); chk("R10 ctrl readback", {24'd0, b}, 32'h87);

    // R1, R2 up counting
    wr(4'd0, 8'h80);
    repeat (3) pulse();
    chk_cnt("R2 up count", 3);
    @(negedge clk); evt = 1'b1;
    @(negedge clk); @(negedge clk);
    rd32(4'd4, v); chk("R1 no change after two edges", v, 3);
    @(negedge clk);
    rd32(4'd4, v); chk("R1 step on third edge", v, 4);
    repeat (4) @(negedge clk);
    rd32(4'd4, v); chk("R1 held input one step", v, 4);
    evt = 1'b0; repeat (3) @(negedge clk);
    m_cnt = 4;

    // R3 disabled counting
    wr(4'd0, 8'h00); pulse(); chk_cnt("R3 hold when disabled", 4);
    // R2 down
    wr(4'd0, 8'h81); pulse(); chk_cnt("R2 down count", 3);

    // R5 key register
    wr(4'd1, 8'h12); rd8(4'd1, b); chk("R5 non-key readback", {24'd0, b}, 0);
    chk_cnt("R5 non-key keeps count", 3);
    wr(4'd1, 8'h55); rd8(4'd1, b); chk("R5 key readback", {24'd0, b}, 32'h55);
    chk_cnt("R5 key clears count", 0);

    // R4 wrap and reload
    pulse(); chk_cnt("R4 wrap below zero", 32'hFFFF_FFFF);
    wr32(4'd12, 32'h20); wr(4'd1, 8'h55);
    wr(4'd0, 8'h80); repeat (3) pulse();
    wr(4'd0, 8'h85); pulse(); pulse();
    chk_cnt("R4 down before zero", 1);
    pulse(); chk_cnt("R4 reload on zero", 32'h20);

    // R6 shadow staging
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h33);
    @(negedge clk); rd32(4'd8, v); chk("R6 staged not committed", v, 0);
    wr(4'd11, 8'h44);
    @(negedge clk); rd32(4'd8, v); chk("R6 committed on low byte", v, 32'h1122_3344);
    m_lvl = 32'h1122_3344;

    // R7 up alarm with hysteresis
    wr(4'd1, 8'h55); wr32(4'd8, 5); wr16_hys(2); wr(4'd0, 8'h82);
    repeat (4) pulse();
    chk_alarm("R7 below level", 1'b0);
    pulse(); chk_alarm("R7 at level", 1'b1);
    wr16_hys(5); wr(4'd1, 8'h55); chk_alarm("R7 held within hysteresis", 1'b1);
    wr16_hys(4); chk_alarm("R7 released past hysteresis", 1'b0);

    // R8 down alarm, released by reload
    wr(4'd0, 8'h80); wr(4'd1, 8'h55);
    wr32(4'd12, 10); wr32(4'd8, 2); wr16_hys(7);
    repeat (3) pulse();
    wr(4'd0, 8'h87); chk_alarm("R8 above level", 1'b0);
    pulse(); chk_alarm("R8 at level", 1'b1);
    pulse(); chk_alarm("R8 below level", 1'b1);
    pulse(); chk_cnt("R8 reload", 10); chk_alarm("R8 released after reload", 1'b0);

    // R9 alarm disable
    wr(4'd0, 8'h83); wr32(4'd8, 20); chk_alarm("R9 alarm set first", 1'b1);
    wr(4'd0, 8'h81); chk_alarm("R9 disabled alarm", 1'b0);
    pulse(); chk_alarm("R9 stays low", 1'b0);

    // random phase against the bench model
    wr32(4'd12, $urandom_range(0, 15));
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      if (op <= 5) pulse();
      else if (op == 6) begin
        d = 8'($urandom);
        wr(4'd0, d);
        rd8(4'd0, b); chk("R10 random ctrl", {24'd0, b}, {24'd0, d & 8'h87});
      end else if (op == 7) begin
        d = ($urandom_range(0, 1) == 1) ? 8'h55 : 8'($urandom);
        wr(4'd1, d);
        rd8(4'd1, b); chk("R5 random key", {24'd0, b}, (d == 8'h55) ? 32'h55 : 0);
      end else if (op == 8) wr32(4'd8, $urandom_range(0, 15));
      else wr16_hys(16'($urandom_range(0, 3)));
      chk_cnt("R2 R3 R4 random count", m_cnt);
      chk_alarm("R7 R8 random alarm", m_alarm);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule